// File: doc/BRIEF.md
# CPU-to-Bus Cycle Debt Synchronizer

This block keeps a bus-side engine in lockstep with a processor that may run faster than its native rate. The processor side reports the number of CPU cycles that have elapsed since its last report. The block turns that count into single-cycle bus-step enables, one per clock, which advance the bus engine by one bus cycle each. It also keeps a running CPU-side clock counter in native cycle units.

A 4-bit speed factor selects the conversion. Factor zero is the native path: two CPU cycles make one bus cycle, the count is halved, and an odd leftover cycle is dropped. A nonzero factor uses a residue accumulator. Each report is added to the residue, and one bus step is issued for every whole multiple of twice the factor that the residue holds. Whatever is left is carried into the next report. The request handshake stays low until the last step owed for the current report has been issued. Software may change the factor only while the block is idle, and a change clears the residue.

Top module: `cyc_debt_sync`

## Requirements
- R1: A synchronous active-high reset clears the residue, the CPU clock counter, any pending steps and the factor. After reset `req_ready` is 1, `bus_step` is 0 and `cpu_clock` is 0.
- R2: With factor 0, an accepted count C adds C to `cpu_clock` and produces exactly C>>1 bus steps. The odd half-cycle is dropped and does not carry into later reports.
- R3: With factor F>0 the threshold is T=2*F. An accepted count C is added to the residue R. The block then issues floor((R+C)/T) steps, and (R+C) mod T carries over to the next report.
- R4: In residue mode each issued step adds exactly 2 to `cpu_clock`. The counter is 48 bits and wraps modulo 2^48.
- R5: Steps appear as `bus_step` pulses on consecutive clocks, at most one per clock. The first pulse comes in the clock after acceptance, and `req_ready` stays low until the last pulse has been issued.
- R6: A factor write (`cfg_we`) takes effect only while no steps are pending, and it clears the residue. A write while steps are pending is ignored. `req_ready` is 0 during any cycle in which `cfg_we` is high.
- R7: Factor 1 gives a native ratio (T=2) but uses the residue path, so an odd leftover cycle is carried over rather than dropped.
- R8: A request presented while `req_ready` is 0 is ignored. With no accepted request and no step, `cpu_clock` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Cycle report present |
| req_cycles | input | 8 | Elapsed CPU cycles in the report |
| req_ready | output | 1 | Block is idle and accepts a report |
| cfg_we | input | 1 | Speed factor write strobe |
| cfg_factor | input | 4 | New speed factor (0 = native path) |
| bus_step | output | 1 | One-clock enable advancing the bus engine one cycle |
| cpu_clock | output | 48 | CPU-side clock counter in native cycle units |

## Verification
Every count from 0 to 40, followed by 254 and 255, is sent in sequence under factors 0, 1, 2, 3, 7 and 15.
- The sequences of odd counts tell the native path, which drops the half-cycle, apart from factor 1, which carries it.
- Counts just under and over multiples of the threshold show that the residue is carried across reports.
- Targeted sequences cover the following:
  - a factor rewrite that must clear a residue that would otherwise yield a step;
  - requests and factor writes presented while steps are pending, which must change neither the step total nor the later behaviour;
  - a reset issued in the middle of a burst.

// File: rtl/cyc_debt_sync.sv
module cyc_debt_sync #(
  parameter int CNT_W = 8,
  parameter int FAC_W = 4,
  parameter int CLK_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [CNT_W-1:0] req_cycles,
  output logic             req_ready,
  input  logic             cfg_we,
  input  logic [FAC_W-1:0] cfg_factor,
  output logic             bus_step,
  output logic [CLK_W-1:0] cpu_clock
);
  localparam int THR_MAX = 2 * ((1 << FAC_W) - 1);
  localparam int DEBT_W  = $clog2(THR_MAX + (1 << CNT_W));

  logic [FAC_W-1:0]  factor;
  logic [DEBT_W-1:0] debt;
  logic [CNT_W-1:0]  pend;

  logic              native;
  logic [DEBT_W-1:0] thr;
  logic              busy;
  logic              accept;
  logic              cfg_ok;

  assign native    = (factor == '0);
  assign thr       = DEBT_W'({factor, 1'b0});
  assign busy      = native ? (pend != '0) : (debt >= thr);
  assign bus_step  = busy;
  assign req_ready = !busy && !cfg_we;
  assign accept    = req_valid && req_ready;
  assign cfg_ok    = cfg_we && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      factor    <= '0;
      debt      <= '0;
      pend      <= '0;
      cpu_clock <= '0;
    end else begin
      if (cfg_ok) begin
        factor <= cfg_factor;
        debt   <= '0;
      end
      if (accept) begin
        if (native) begin
          cpu_clock <= cpu_clock + CLK_W'(req_cycles);
          pend      <= req_cycles >> 1;
        end else begin
          debt <= debt + DEBT_W'(req_cycles);
        end
      end else if (busy) begin
        if (native) begin
          pend <= pend - 1'b1;
        end else begin
          debt      <= debt - thr;
          cpu_clock <= cpu_clock + CLK_W'(2);
        end
      end
    end
  end
endmodule

// File: rtl/cyc_debt_sync_chk.sv
module cyc_debt_sync_chk #(
  parameter int CNT_W  = 8,
  parameter int FAC_W  = 4,
  parameter int CLK_W  = 48,
  parameter int DEBT_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [CNT_W-1:0]  req_cycles,
  input logic              req_ready,
  input logic              cfg_we,
  input logic              bus_step,
  input logic [CLK_W-1:0]  cpu_clock,
  input logic [FAC_W-1:0]  factor,
  input logic [DEBT_W-1:0] debt,
  input logic [CNT_W-1:0]  pend
);
  logic              p_valid, p_step, p_native, p_acc, p_cfg;
  logic [CNT_W-1:0]  p_cyc, p_pend;
  logic [CLK_W-1:0]  p_clk;
  logic [DEBT_W-1:0] p_debt, p_thr;

  always_ff @(posedge clk) begin
    p_valid  <= !rst;
    p_step   <= bus_step;
    p_native <= (factor == '0);
    p_acc    <= req_valid && req_ready;
    p_cfg    <= cfg_we && !bus_step;
    p_cyc    <= req_cycles;
    p_pend   <= pend;
    p_clk    <= cpu_clock;
    p_debt   <= debt;
    p_thr    <= DEBT_W'({factor, 1'b0});
  end

  a_r4_clock_plus_two: assert property (@(posedge clk) disable iff (rst)
    p_valid && p_step && !p_native |-> cpu_clock == p_clk + CLK_W'(2));

  a_r3_residue_drops_thr: assert property (@(posedge clk) disable iff (rst)
    p_valid && p_step && !p_native |-> debt == p_debt - p_thr);

  a_r2_native_clock_add: assert property (@(posedge clk) disable iff (rst)
    p_valid && p_acc && p_native |-> cpu_clock == p_clk + CLK_W'(p_cyc));

  a_r5_pend_countdown: assert property (@(posedge clk) disable iff (rst)
    p_valid && p_step && p_native |-> pend == p_pend - 1'b1);

  a_r6_write_clears: assert property (@(posedge clk) disable iff (rst)
    p_valid && p_cfg |-> debt == '0);

  a_r8_idle_clock_hold: assert property (@(posedge clk) disable iff (rst)
    p_valid && !p_acc && !p_step |-> cpu_clock == p_clk);
endmodule

bind cyc_debt_sync cyc_debt_sync_chk #(
  .CNT_W(CNT_W), .FAC_W(FAC_W), .CLK_W(CLK_W), .DEBT_W(DEBT_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_cycles(req_cycles),
  .req_ready(req_ready), .cfg_we(cfg_we), .bus_step(bus_step),
  .cpu_clock(cpu_clock), .factor(factor), .debt(debt), .pend(pend)
);

// File: tb/cyc_debt_sync_tb.sv
module cyc_debt_sync_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [7:0]  req_cycles = '0;
  logic        req_ready;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_factor = '0;
  logic        bus_step;
  logic [47:0] cpu_clock;

  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;
  int          fac_m = 0;
  int          debt_m = 0;
  logic [47:0] clk_m = '0;

  always #5 clk = ~clk;

  cyc_debt_sync u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cycles(req_cycles),
    .req_ready(req_ready), .cfg_we(cfg_we), .cfg_factor(cfg_factor),
    .bus_step(bus_step), .cpu_clock(cpu_clock)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_factor(input int f);
    cfg_we = 1'b1;
    cfg_factor = 4'(f);
    #1;
    check(req_ready == 1'b0, "R6 ready low during write", longint'(req_ready), 0);
    @(negedge clk);
    cfg_we = 1'b0;
    fac_m = f;
    debt_m = 0;
  endtask

  task automatic send(input int c, input string tag);
    int got;
    int exp_steps;
    int guard;
    guard = 0;
    while (!req_ready && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    req_valid = 1'b1;
    req_cycles = 8'(c);
    @(negedge clk);
    req_valid = 1'b0;
    got = 0;
    guard = 0;
    while (!req_ready && guard < 2000) begin
      if (bus_step) got++;
      @(negedge clk);
      guard++;
    end
    if (fac_m == 0) begin
      exp_steps = c >> 1;
      clk_m = clk_m + 48'(c);
    end else begin
      debt_m = debt_m + c;
      exp_steps = debt_m / (2 * fac_m);
      debt_m = debt_m % (2 * fac_m);
      clk_m = clk_m + 48'(2 * exp_steps);
    end
    check(got == exp_steps, tag, got, exp_steps);
    check(cpu_clock == clk_m, tag, longint'(cpu_clock), longint'(clk_m));
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int facs[6] = '{0, 1, 2, 3, 7, 15};
    int got;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(req_ready == 1'b1, "R1 ready after reset", longint'(req_ready), 1);
    check(bus_step == 1'b0, "R1 no step after reset", longint'(bus_step), 0);
    check(cpu_clock == 48'd0, "R1 clock after reset", longint'(cpu_clock), 0);

    foreach (facs[i]) begin
      set_factor(facs[i]);
      for (int c = 0; c <= 40; c++)
        send(c, facs[i] == 0 ? "R2 native sweep" : (facs[i] == 1 ? "R7 factor one sweep" : "R3 R4 residue sweep"));
      send(254, facs[i] == 0 ? "R2 native large" : "R3 residue large");
      send(255, facs[i] == 0 ? "R2 native large odd" : "R3 residue large odd");
    end

    set_factor(0);
    send(3, "R2 odd drop first");
    send(3, "R2 odd drop second");
    set_factor(1);
    send(3, "R7 carry first");
    send(3, "R7 carry second");

    set_factor(3);
    send(5, "R3 below threshold");
    set_factor(3);
    send(5, "R6 residue cleared by write");

    set_factor(0);
    req_valid = 1'b1;
    req_cycles = 8'd20;
    @(negedge clk);
    got = 0;
    check(bus_step == 1'b1 && req_ready == 1'b0, "R5 first step after accept", longint'(bus_step), 1);
    req_cycles = 8'd50;
    cfg_we = 1'b1;
    cfg_factor = 4'd5;
    for (int k = 0; k < 3; k++) begin
      if (bus_step) got++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    cfg_we = 1'b0;
    while (!req_ready && got < 200) begin
      if (bus_step) got++;
      @(negedge clk);
    end
    clk_m = clk_m + 48'd20;
    check(got == 10, "R8 busy request ignored", got, 10);
    check(cpu_clock == clk_m, "R8 clock after busy request", longint'(cpu_clock), longint'(clk_m));
    send(7, "R6 busy write ignored");

    send(30, "R5 burst before reset");
    req_valid = 1'b1;
    req_cycles = 8'd40;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(bus_step == 1'b0, "R1 reset drops pending steps", longint'(bus_step), 0);
    check(cpu_clock == 48'd0, "R1 reset clears clock", longint'(cpu_clock), 0);
    check(req_ready == 1'b1, "R1 ready after mid reset", longint'(req_ready), 1);
    clk_m = '0;
    fac_m = 0;
    debt_m = 0;
    repeat (4) @(negedge clk);
    check(cpu_clock == 48'd0, "R8 idle clock holds", longint'(cpu_clock), 0);
    send(9, "R2 native after reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule